// File: doc/BRIEF.md
# Tournament Conditional-Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It has three tables. The first is a global table of 3-bit saturating counters. It is indexed by XORing branch address bits with a global outcome history. The second is a two-level local component. Its first level keeps a per-branch outcome history, selected by low address bits. Its second level holds 2-bit counters indexed by XORing address bits with that history. The third is a chooser table of 2-bit counters, indexed by address bits, which decides which of the two components supplies the final prediction.

A front-end stage presents a branch address on the predict port. In the same cycle it reads back the final direction and both component directions. When the branch resolves, the pipeline presents the address, the real outcome and the two component directions it recorded at predict time on the update port. Updates land on the next clock edge. Speculative history repair, target prediction and target buffers belong to other blocks.

The address ports carry word-address bits, with the byte offset already stripped. Their width is the widest index any table uses. Table sizes are parameters. At full size the block holds a 16K-entry global table, 256 local histories of 12 bits, 4K local counters and 4K chooser counters, about 67 Kb in all. The default parameters are smaller.

Top module: `tourney_pred`

## Requirements
- R1: After reset, every global counter holds 3 (binary 011), every local and chooser counter holds 1 (binary 01), and the global history and every local history are zero. So at every address all three predictions read not-taken.
- R2: The global prediction is the most significant bit of the 3-bit counter at index `pc[GH_W-1:0] XOR ghist`.
- R3: The local prediction is the most significant bit of the 2-bit counter at index `pc[LH_W-1:0] XOR lhist`. Here `lhist` is the LH_W-bit history entry selected by `pc[L1_W-1:0]`.
- R4: The chooser counter at `pc[SEL_W-1:0]` selects the source. Its most significant bit at 1 picks the global prediction and at 0 picks the local one, and `pred_taken` equals the picked prediction.
- R5: Counters step by one toward the outcome and saturate: 3-bit counters between 0 and 7, 2-bit counters between 0 and 3.
- R6: On a valid update, the chooser moves one step toward global when `upd_glob` equals the outcome and `upd_loc` does not. It moves one step toward local in the opposite case, and does not change when `upd_glob` equals `upd_loc`.
- R7: On a valid update, the global and local counters addressed as in R2 and R3 (using the update address and the pre-update histories) both train on the outcome. The outcome is then shifted into bit 0 of the global history and of the branch's local history, and the oldest bit is dropped.
- R8: While `upd_valid` is low, no counter and no history changes.
- R9: Predictions follow the predict address combinationally. An update changes predictions from the first clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PCI_W | Word address of the branch being predicted |
| pred_taken | output | 1 | Final direction |
| pred_glob | output | 1 | Global component direction |
| pred_loc | output | 1 | Local component direction |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | PCI_W | Word address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_glob | input | 1 | Global direction recorded at predict time |
| upd_loc | input | 1 | Local direction recorded at predict time |

## Verification
The bench uses a configuration with 4-bit indices and a 16-address space, and compares every cycle against an arithmetic model of the three tables.

A single address that is always taken drives counters into saturation. A flip on that address then shows whether the counter stops at its limit or wraps. An alternating outcome on one address fills the histories, which tells correct bit-0 insertion apart from a wrong shift direction. Four interleaved branches with a repeating three-taken, one-not-taken pattern make the components disagree, which exercises the chooser in both directions.

A long pseudo-random stream of addresses and outcomes separates the hash, the index selection and the history updates. Full address sweeps with the update strobe low, taken just after reset and after training, show that nothing moves without a valid update.

// File: rtl/tp_pkg.sv
package tp_pkg;

  localparam int GCNT_W = 3;
  localparam int LCNT_W = 2;
  localparam int SCNT_W = 2;

  typedef enum logic {
    SRC_LOCAL  = 1'b0,
    SRC_GLOBAL = 1'b1
  } tp_src_e;

  function automatic int tp_max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int tp_max4(input int a, input int b, input int c, input int d);
    return tp_max2(tp_max2(a, b), tp_max2(c, d));
  endfunction

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
  parameter int IDX_W = 10,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CINIT = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] wr_old;
  logic [CNT_W-1:0] wr_nx;

  always_comb begin
    wr_old = cnt_q[wr_idx];
    wr_nx  = wr_old;
    if (wr_up) begin
      if (wr_old != CMAX) wr_nx = wr_old + 1'b1;
    end else begin
      if (wr_old != '0) wr_nx = wr_old - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CINIT;
    end else if (wr_en) begin
      cnt_q[wr_idx] <= wr_nx;
    end
  end

  assign rd_taken = cnt_q[rd_idx][CNT_W-1];

  // Checking state: remembers the last written entry and its old value
  logic             chk_v_q;
  logic             chk_up_q;
  logic [IDX_W-1:0] chk_idx_q;
  logic [CNT_W-1:0] chk_old_q;
  logic [CNT_W:0]   chk_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v_q   <= 1'b0;
      chk_up_q  <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= '0;
    end else begin
      chk_v_q <= wr_en;
      if (wr_en) begin
        chk_up_q  <= wr_up;
        chk_idx_q <= wr_idx;
        chk_old_q <= wr_old;
      end
    end
  end

  assign chk_now = {1'b0, cnt_q[chk_idx_q]};

  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v_q |-> (chk_now == {1'b0, chk_old_q} + 1'b1) ||
                (chk_now + 1'b1 == {1'b0, chk_old_q}) ||
                (chk_now == {1'b0, chk_old_q}));

  // R5
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v_q && chk_up_q && chk_old_q == CMAX) |-> cnt_q[chk_idx_q] == CMAX);

  // R5
  sat_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v_q && !chk_up_q && chk_old_q == '0) |-> cnt_q[chk_idx_q] == '0);

endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
  parameter int L1_W = 6,
  parameter int LH_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [L1_W-1:0] rd_a_idx,
  output logic [LH_W-1:0] rd_a_hist,
  input  logic [L1_W-1:0] rd_b_idx,
  output logic [LH_W-1:0] rd_b_hist,
  input  logic            wr_en,
  input  logic            wr_bit
);

  localparam int DEPTH = 1 << L1_W;

  logic [LH_W-1:0] hist_q [DEPTH];
  logic [LH_W-1:0] hist_nx;

  assign rd_a_hist = hist_q[rd_a_idx];
  assign rd_b_hist = hist_q[rd_b_idx];

  generate
    if (LH_W > 1) begin : g_shift
      always_comb hist_nx = {rd_b_hist[LH_W-2:0], wr_bit};
    end else begin : g_single
      always_comb hist_nx = wr_bit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[rd_b_idx] <= hist_nx;
    end
  end

  logic            chk_v_q;
  logic            chk_bit_q;
  logic [L1_W-1:0] chk_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v_q   <= 1'b0;
      chk_bit_q <= 1'b0;
      chk_idx_q <= '0;
    end else begin
      chk_v_q <= wr_en;
      if (wr_en) begin
        chk_bit_q <= wr_bit;
        chk_idx_q <= rd_b_idx;
      end
    end
  end

  // R7
  lhist_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v_q |-> hist_q[chk_idx_q][0] == chk_bit_q);

endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int GH_W  = 10,
  parameter int L1_W  = 6,
  parameter int LH_W  = 10,
  parameter int SEL_W = 10,
  localparam int PCI_W = tp_max4(GH_W, L1_W, LH_W, SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PCI_W-1:0] pred_pc,
  output logic             pred_taken,
  output logic             pred_glob,
  output logic             pred_loc,
  input  logic             upd_valid,
  input  logic [PCI_W-1:0] upd_pc,
  input  logic             upd_taken,
  input  logic             upd_glob,
  input  logic             upd_loc
);

  // Global history register
  logic [GH_W-1:0] ghist_q;
  logic [GH_W-1:0] ghist_d;

  generate
    if (GH_W > 1) begin : g_gh_shift
      always_comb ghist_d = upd_valid ? {ghist_q[GH_W-2:0], upd_taken} : ghist_q;
    end else begin : g_gh_single
      always_comb ghist_d = upd_valid ? upd_taken : ghist_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghist_q <= '0;
    else        ghist_q <= ghist_d;
  end

  // Global component
  logic [GH_W-1:0] g_rd_idx;
  logic [GH_W-1:0] g_wr_idx;

  assign g_rd_idx = pred_pc[GH_W-1:0] ^ ghist_q;
  assign g_wr_idx = upd_pc[GH_W-1:0]  ^ ghist_q;

  tp_sat_table #(.IDX_W(GH_W), .CNT_W(GCNT_W)) u_glob_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (g_rd_idx),
    .rd_taken (pred_glob),
    .wr_en    (upd_valid),
    .wr_idx   (g_wr_idx),
    .wr_up    (upd_taken)
  );

  // Local component: first-level histories, second-level counters
  logic [LH_W-1:0] lh_pred;
  logic [LH_W-1:0] lh_upd;

  tp_local_hist #(.L1_W(L1_W), .LH_W(LH_W)) u_lhist (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (pred_pc[L1_W-1:0]),
    .rd_a_hist (lh_pred),
    .rd_b_idx  (upd_pc[L1_W-1:0]),
    .rd_b_hist (lh_upd),
    .wr_en     (upd_valid),
    .wr_bit    (upd_taken)
  );

  logic [LH_W-1:0] l_rd_idx;
  logic [LH_W-1:0] l_wr_idx;

  assign l_rd_idx = pred_pc[LH_W-1:0] ^ lh_pred;
  assign l_wr_idx = upd_pc[LH_W-1:0]  ^ lh_upd;

  tp_sat_table #(.IDX_W(LH_W), .CNT_W(LCNT_W)) u_loc_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (l_rd_idx),
    .rd_taken (pred_loc),
    .wr_en    (upd_valid),
    .wr_idx   (l_wr_idx),
    .wr_up    (upd_taken)
  );

  // Chooser
  logic    sel_rd;
  tp_src_e sel_src;
  logic    sel_we;
  logic    sel_toward_glob;

  assign sel_we          = upd_valid && (upd_glob != upd_loc);
  assign sel_toward_glob = (upd_glob == upd_taken);

  tp_sat_table #(.IDX_W(SEL_W), .CNT_W(SCNT_W)) u_sel_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pred_pc[SEL_W-1:0]),
    .rd_taken (sel_rd),
    .wr_en    (sel_we),
    .wr_idx   (upd_pc[SEL_W-1:0]),
    .wr_up    (sel_toward_glob)
  );

  assign sel_src    = sel_rd ? SRC_GLOBAL : SRC_LOCAL;
  assign pred_taken = (sel_src == SRC_GLOBAL) ? pred_glob : pred_loc;

  // R7
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist_q[0] == $past(upd_taken));

  // R8
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist_q));

  // R4
  agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_glob == pred_loc) |-> pred_taken == pred_glob);

endmodule

// File: tb/tourney_pred_bench.sv
module tourney_pred_bench;

  localparam int GH_W  = 4;
  localparam int L1_W  = 2;
  localparam int LH_W  = 4;
  localparam int SEL_W = 4;
  localparam int PCI_W = 4;
  localparam int NPC   = 1 << PCI_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [PCI_W-1:0] pred_pc;
  logic             pred_taken;
  logic             pred_glob;
  logic             pred_loc;
  logic             upd_valid;
  logic [PCI_W-1:0] upd_pc;
  logic             upd_taken;
  logic             upd_glob;
  logic             upd_loc;

  always #4 clk = ~clk;

  tourney_pred #(.GH_W(GH_W), .L1_W(L1_W), .LH_W(LH_W), .SEL_W(SEL_W)) u_tourney_pred (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .pred_glob  (pred_glob),
    .pred_loc   (pred_loc),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_glob   (upd_glob),
    .upd_loc    (upd_loc)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Arithmetic model of the tables
  int m_g [16];
  int m_l [16];
  int m_s [16];
  int m_lh [4];
  int m_gh;

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_g[i] = 3; m_l[i] = 1; m_s[i] = 1;
    end
    for (int i = 0; i < 4; i++) m_lh[i] = 0;
    m_gh = 0;
  endtask

  function automatic bit mg(input int pc);
    return m_g[(pc ^ m_gh) & 15] >= 4;
  endfunction
  function automatic bit ml(input int pc);
    return m_l[(pc & 15) ^ m_lh[pc & 3]] >= 2;
  endfunction
  function automatic bit mt(input int pc);
    return (m_s[pc & 15] >= 2) ? mg(pc) : ml(pc);
  endfunction

  task automatic model_update(input int pc, input bit t, input bit g, input bit l);
    int gi, li, si;
    gi = (pc ^ m_gh) & 15;
    li = (pc & 15) ^ m_lh[pc & 3];
    si = pc & 15;
    if (g != l) begin
      if (g == t) m_s[si] = (m_s[si] < 3) ? m_s[si] + 1 : 3;
      else        m_s[si] = (m_s[si] > 0) ? m_s[si] - 1 : 0;
    end
    if (t) begin
      m_g[gi] = (m_g[gi] < 7) ? m_g[gi] + 1 : 7;
      m_l[li] = (m_l[li] < 3) ? m_l[li] + 1 : 3;
    end else begin
      m_g[gi] = (m_g[gi] > 0) ? m_g[gi] - 1 : 0;
      m_l[li] = (m_l[li] > 0) ? m_l[li] - 1 : 0;
    end
    m_lh[pc & 3] = ((m_lh[pc & 3] << 1) | int'(t)) & 15;
    m_gh = ((m_gh << 1) | int'(t)) & 15;
  endtask

  task automatic check(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One cycle: present pc on both ports, check predictions, optionally update
  task automatic step(input int pc, input bit t, input bit v, input string req);
    bit eg, el, et;
    @(negedge clk);
    eg = mg(pc); el = ml(pc); et = mt(pc);
    pred_pc   = PCI_W'(pc);
    upd_pc    = PCI_W'(pc);
    upd_taken = t;
    upd_valid = v;
    upd_glob  = eg;
    upd_loc   = el;
    #1;
    // R2 global direction, R3 local direction, R9 same-cycle read of prior updates
    check(pred_glob, eg, "R2", "pred_glob");
    check(pred_loc,  el, "R3", "pred_loc");
    check(pred_taken, et, req, "pred_taken");
    if (v) model_update(pc, t, eg, el);
  endtask

  task automatic idle_sweep(input string req);
    for (int p = 0; p < NPC; p++) step(p, p[0], 1'b0, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    pred_pc = '0; upd_pc = '0; upd_valid = 1'b0;
    upd_taken = 1'b0; upd_glob = 1'b0; upd_loc = 1'b0;
    do_reset();

    // R1: all three predictions not-taken everywhere after reset
    for (int p = 0; p < NPC; p++) begin
      @(negedge clk);
      pred_pc = PCI_W'(p);
      #1;
      check(pred_taken, 1'b0, "R1", "reset pred_taken");
      check(pred_glob,  1'b0, "R1", "reset pred_glob");
      check(pred_loc,   1'b0, "R1", "reset pred_loc");
    end

    // R8: update strobe low, outcome toggling, nothing moves
    idle_sweep("R8");
    for (int p = 0; p < NPC; p++) step(p, 1'b1, 1'b0, "R8");

    // R5: one address driven to saturation, then a single flip
    for (int i = 0; i < 14; i++) step(5, 1'b1, 1'b1, "R5");
    step(5, 1'b0, 1'b1, "R5");
    for (int i = 0; i < 4; i++) step(5, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 14; i++) step(9, 1'b0, 1'b1, "R5");

    // R7: alternating outcome on one address fills the histories
    for (int i = 0; i < 40; i++) step(2, i[0], 1'b1, "R7");

    // R6: interleaved loop-like branches, three taken then one not-taken
    for (int i = 0; i < 240; i++) step(i % 4 + 4 * ((i / 4) % 4), (i / 4) % 4 != 3, 1'b1, "R6");

    // R4 / R9: pseudo-random addresses and outcomes
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(int'(lfsr[3:0]), (lfsr[7:4] > 4'd5), 1'b1, (i % 2 == 0) ? "R4" : "R9");
      end
    end

    // R8: trained state must survive idle cycles
    idle_sweep("R8");
    for (int i = 0; i < 30; i++) step(i % NPC, 1'b1, 1'b1, "R9");
    idle_sweep("R8");

    // R1: reset in the middle of a run restores the initial state
    do_reset();
    for (int p = 0; p < NPC; p++) begin
      @(negedge clk);
      pred_pc = PCI_W'(p);
      #1;
      check(pred_taken, 1'b0, "R1", "rereset pred_taken");
      check(pred_glob,  1'b0, "R1", "rereset pred_glob");
      check(pred_loc,   1'b0, "R1", "rereset pred_loc");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule